// File: doc/BRIEF.md
# I2C Register Target with Deferred Non-Volatile Commit

This block is an I2C target that serves a small bank of byte registers. Every data register has two copies: a working copy that changes at once, and a backing copy that stands in for non-volatile storage. One control register picks which copy is used. Its bit 7 is the copy-select bit: 0 selects the working copy and 1 selects the backing copy. The selection applies both to writes into data registers and to reads from them. The control register lives at address 08h and has a single copy.

A write aimed at the backing copy is not applied straight away. It waits in a pending slot and lands in the backing store only when a STOP closes the transfer. A repeated START throws it away instead. When the write lands, the block raises a one-cycle commit pulse and presents the address and data beside it. Multi-byte writes are legal only when they start at address 08h. Reads can name an address first and then use a repeated START. They can also begin directly, in which case they continue from the register after the one last accessed. SCL and SDA are taken in through synchronizers and sampled by the system clock. SDA is driven open-drain through an output enable.

Top module: `i2c_reg_target`

## Requirements
- R1: The target answers only its own 7-bit address (default 2Ch) with an ACK. For any other address it keeps SDA released through the ACK slot and every following byte, until the next START, and no register changes.
- R2: The sequence START, address with R/W=0, memory address, one data byte, STOP writes that byte. When the copy-select bit (control register 08h, bit 7) is 0, the byte goes to the working copy of a data register. A byte written to 08h always goes to the control register.
- R3: With the copy-select bit at 1, a data-register write is held pending and reaches the backing copy only at the STOP. That STOP causes exactly one one-cycle commit pulse carrying the address and data. Reads of data registers return the backing copy when the bit is 1 and the working copy when it is 0. A read of 08h always returns the control register.
- R4: A pending backing-copy write that is followed by a repeated START instead of a STOP is discarded. No commit pulse occurs and the backing copy keeps its old value.
- R5: A write burst whose memory address byte is 08h accepts consecutive bytes, with the address rising by one after each byte. The first accepted byte that targets a backing copy ends the burst, and every later byte gets a NACK and is dropped.
- R6: A write burst whose memory address byte is not 08h accepts only its first data byte. The second byte gets a NACK and is not written.
- R7: A read that follows an address phase and a repeated START returns the named register first. The address then rises by one, modulo the register count of 16, for each byte the master ACKs. A master NACK ends the read and releases SDA.
- R8: A read that begins without an address phase returns the register one above the last accessed one. After reset this is register 01h.
- R9: After reset, SDA is released and no commit pulse is present. Both copies of register i hold A0h XOR i, and the control register holds 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| nv_commit | output | 1 | One-cycle pulse when a backing-copy write lands |
| nv_commit_addr | output | 4 | Register address of the write that landed |
| nv_commit_data | output | 8 | Data byte of the write that landed |

## Verification
Write bursts are driven from 08h and from other start addresses, and with the copy-select bit both clear and set. Comparing the ACK seen for every byte separates the burst rule from the single-byte rule and from the rule that ends a burst at its first backing-copy byte. Backing-copy writes are closed once by STOP and once by a repeated START; the commit pulse and a later read-back show whether the commit waits for the STOP. Reads are tried with an address phase, without one, and across the top of the map, which checks the pointer after reset, after writes and after reads. A write to a foreign address, followed by a read-back, shows that the rest of that transfer is ignored.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_SACK,
      ST_TX,
      ST_MACK
   } link_st_e;

   typedef enum logic [1:0] {
      K_DEV,
      K_MEM,
      K_DATA
   } byte_kind_e;
endpackage

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond #(
   parameter int NSYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [1:0] raw;
   logic [1:0] synced;
   logic       scl_s;
   logic       scl_p;
   logic       sda_p;

   assign raw = {scl_i, sda_i};

   if (NSYNC < 2) begin : g_bad_sync
      $error("NSYNC must be at least 2");
   end

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [NSYNC-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else        ff <= {ff[NSYNC-2:0], raw[g]};
      end
      assign synced[g] = ff[NSYNC-1];
   end

   assign scl_s = synced[1];
   assign sda_s = synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rs_link.sv
module i2c_rs_link
   import i2c_rs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h2C,
   parameter int         AW         = 4,
   parameter int         CTRL_ADDR  = 8,
   parameter logic [7:0] BURST_ADDR = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              nv_sel,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [AW-1:0]     rd_addr
);
   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

   link_st_e          st;
   byte_kind_e        kind;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic [BYTE_W-1:0] rx_byte;
   logic [AW-1:0]     nxt;
   logic              ack_q, rw_q, mack_q;
   logic              burst_ok, got_one, nv_done;
   logic              byte_end, accept_c, ack_c;

   assign rx_byte  = {shreg[BYTE_W-2:0], sda_s};
   assign byte_end = (st == ST_RX) && scl_rise && (bitcnt == 4'd7);
   assign accept_c = !nv_done && (!got_one || burst_ok);

   always_comb begin
      case (kind)
         K_DEV:   ack_c = (rx_byte[7:1] == DEV_ADDR);
         K_MEM:   ack_c = 1'b1;
         default: ack_c = accept_c;
      endcase
   end

   assign wr_en   = byte_end && (kind == K_DATA) && accept_c;
   assign wr_addr = nxt;
   assign wr_data = rx_byte;
   assign rd_addr = nxt;
   assign sda_oe  = ((st == ST_SACK) && ack_q) || ((st == ST_TX) && !txreg[BYTE_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind     <= K_DEV;
         bitcnt   <= '0;
         shreg    <= '0;
         txreg    <= '0;
         nxt      <= AW'(1);
         ack_q    <= 1'b0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         burst_ok <= 1'b0;
         got_one  <= 1'b0;
         nv_done  <= 1'b0;
      end else if (start_ev) begin
         st     <= ST_RX;
         kind   <= K_DEV;
         bitcnt <= '0;
      end else if (stop_ev) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  shreg  <= rx_byte;
                  bitcnt <= bitcnt + 4'd1;
               end
               if (byte_end) begin
                  ack_q <= ack_c;
                  case (kind)
                     K_DEV: rw_q <= rx_byte[0];
                     K_MEM: begin
                        nxt      <= rx_byte[AW-1:0];
                        burst_ok <= (rx_byte == BURST_ADDR);
                        got_one  <= 1'b0;
                        nv_done  <= 1'b0;
                     end
                     default: if (accept_c) begin
                        nxt     <= nxt + 1'b1;
                        got_one <= 1'b1;
                        if (nv_sel && nxt != CTRL_A) nv_done <= 1'b1;
                     end
                  endcase
               end
               if (scl_fall && bitcnt == 4'd8) st <= ST_SACK;
            end
            ST_SACK: if (scl_fall) begin
               bitcnt <= '0;
               if (!ack_q) st <= ST_IDLE;
               else if (kind == K_DEV && rw_q) begin
                  st    <= ST_TX;
                  txreg <= rd_data;
                  nxt   <= nxt + 1'b1;
               end else begin
                  st   <= ST_RX;
                  kind <= (kind == K_DEV) ? K_MEM : K_DATA;
               end
            end
            ST_TX: if (scl_fall) begin
               if (bitcnt == 4'd7) st <= ST_MACK;
               else begin
                  txreg  <= {txreg[BYTE_W-2:0], 1'b1};
                  bitcnt <= bitcnt + 4'd1;
               end
            end
            ST_MACK: begin
               if (scl_rise) mack_q <= ~sda_s;
               if (scl_fall) begin
                  if (mack_q) begin
                     st     <= ST_TX;
                     txreg  <= rd_data;
                     nxt    <= nxt + 1'b1;
                     bitcnt <= '0;
                  end else st <= ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   // R1: the target changes SDA only just after SCL falls or at a bus condition
   p_sda_moves_low_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
   parameter int         NREG      = 16,
   parameter int         AW        = 4,
   parameter int         DW        = 8,
   parameter int         CTRL_ADDR = 8,
   parameter int         SEL_BIT   = 7,
   parameter logic [7:0] INIT_XOR  = 8'hA0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   input  logic          start_ev,
   input  logic          stop_ev,
   output logic [DW-1:0] rd_data,
   output logic          nv_sel,
   output logic          nv_commit,
   output logic [AW-1:0] nv_commit_addr,
   output logic [DW-1:0] nv_commit_data
);
   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

   logic [DW-1:0] vol [NREG];
   logic [DW-1:0] nv  [NREG];
   logic [DW-1:0] ctrl;
   logic          pend_v;
   logic [AW-1:0] pend_a;
   logic [DW-1:0] pend_d;

   function automatic logic [DW-1:0] init_val(int i);
      return DW'(INIT_XOR) ^ DW'(i);
   endfunction

   assign nv_sel  = ctrl[SEL_BIT];
   assign rd_data = (rd_addr == CTRL_A) ? ctrl : (nv_sel ? nv[rd_addr] : vol[rd_addr]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            vol[i] <= init_val(i);
            nv[i]  <= init_val(i);
         end
         ctrl           <= '0;
         pend_v         <= 1'b0;
         pend_a         <= '0;
         pend_d         <= '0;
         nv_commit      <= 1'b0;
         nv_commit_addr <= '0;
         nv_commit_data <= '0;
      end else begin
         nv_commit <= 1'b0;
         if (start_ev) pend_v <= 1'b0;
         else if (stop_ev && pend_v) begin
            nv[pend_a]     <= pend_d;
            nv_commit      <= 1'b1;
            nv_commit_addr <= pend_a;
            nv_commit_data <= pend_d;
            pend_v         <= 1'b0;
         end
         if (wr_en) begin
            if (wr_addr == CTRL_A) ctrl <= wr_data;
            else if (nv_sel) begin
               pend_v <= 1'b1;
               pend_a <= wr_addr;
               pend_d <= wr_data;
            end else vol[wr_addr] <= wr_data;
         end
      end
   end

   // R3: a commit follows a STOP seen while a write was pending
   p_commit_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nv_commit |-> $past(stop_ev && pend_v));
   // R4: a START drops the pending write and never commits it
   p_abort_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !pend_v && !nv_commit);
   // R5: the link never offers a second backing-copy write in one transfer
   p_one_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> !(wr_en && nv_sel && wr_addr != CTRL_A));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter logic [6:0] DEV_ADDR   = 7'h2C,
   parameter int         NREG       = 16,
   parameter int         CTRL_ADDR  = 8,
   parameter logic [7:0] BURST_ADDR = 8'h08,
   parameter int         SEL_BIT    = 7,
   parameter logic [7:0] INIT_XOR   = 8'hA0,
   parameter int         NSYNC      = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   output logic                    nv_commit,
   output logic [$clog2(NREG)-1:0] nv_commit_addr,
   output logic [7:0]              nv_commit_data
);
   localparam int AW = $clog2(NREG);
   localparam int DW = i2c_rs_pkg::BYTE_W;

   if (NREG != (1 << AW) || AW > DW) begin : g_bad_nreg
      $error("NREG must be a power of two of at most 256");
   end
   if (CTRL_ADDR >= NREG) begin : g_bad_ctrl
      $error("CTRL_ADDR must lie inside the map");
   end
   if (SEL_BIT >= DW) begin : g_bad_sel
      $error("SEL_BIT must lie inside a byte");
   end

   logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic          nv_sel, wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [DW-1:0] wr_data, rd_data;

   i2c_rs_cond #(.NSYNC(NSYNC)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   i2c_rs_link #(
      .DEV_ADDR(DEV_ADDR), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .BURST_ADDR(BURST_ADDR)
   ) u_link (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .nv_sel(nv_sel), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
   );

   i2c_rs_regs #(
      .NREG(NREG), .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
      .SEL_BIT(SEL_BIT), .INIT_XOR(INIT_XOR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .start_ev(start_ev),
      .stop_ev(stop_ev), .rd_data(rd_data), .nv_sel(nv_sel),
      .nv_commit(nv_commit), .nv_commit_addr(nv_commit_addr),
      .nv_commit_data(nv_commit_data)
   );
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
   localparam logic [6:0] DEV = 7'h2C;
   localparam int Q = 8;

   typedef logic [7:0] bq_t[$];

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, nv_commit;
   logic [3:0] nv_commit_addr;
   logic [7:0] nv_commit_data;
   wire  sda_bus = sda_m & ~sda_oe;

   i2c_reg_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .nv_commit(nv_commit),
      .nv_commit_addr(nv_commit_addr), .nv_commit_data(nv_commit_data)
   );

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [7:0] m_vol [16];
   logic [7:0] m_nv  [16];
   logic [7:0] m_ctrl;
   int  m_nxt;
   bit  m_pend;
   int  m_pa;
   logic [7:0] m_pd;
   bit  exp_commit = 0;
   bit  got_commit = 0;
   bit  bus_idle = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model compared on every clock: commit pulses and bus release
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (nv_commit) begin
            got_commit = 1;
            chk(exp_commit && nv_commit_addr == 4'(m_pa) && nv_commit_data == m_pd,
                "R3", {nv_commit_addr, nv_commit_data}, {4'(m_pa), m_pd});
         end
         if (bus_idle && sda_oe) chk(0, "R1", 1, 0);
      end
   end

   function automatic logic [7:0] m_read(input int a);
      if (a == 8) return m_ctrl;
      return m_ctrl[7] ? m_nv[a] : m_vol[a];
   endfunction

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1; scl_m = 1; qwait();
      sda_m = 0; qwait();
      scl_m = 0; qwait();
   endtask

   task automatic i2c_rstart();
      sda_m = 1; qwait();
      scl_m = 1; qwait();
      sda_m = 0; qwait();
      scl_m = 0; qwait();
   endtask

   task automatic i2c_stop();
      sda_m = 0; qwait();
      scl_m = 1; qwait();
      sda_m = 1; qwait();
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; qwait();
         scl_m = 1; qwait(); qwait();
         scl_m = 0; qwait();
      end
      sda_m = 1; qwait();
      scl_m = 1; qwait();
      ack = !sda_bus; qwait();
      scl_m = 0; qwait();
   endtask

   task automatic rbyte(output logic [7:0] v, input bit ack);
      v = '0;
      for (int i = 0; i < 8; i++) begin
         sda_m = 1; qwait();
         scl_m = 1; qwait();
         v = {v[6:0], sda_bus}; qwait();
         scl_m = 0; qwait();
      end
      sda_m = ack ? 1'b0 : 1'b1; qwait();
      scl_m = 1; qwait(); qwait();
      scl_m = 0; qwait();
   endtask

   task automatic finish_stop();
      exp_commit = m_pend;
      got_commit = 0;
      i2c_stop();
      repeat (6) @(negedge clk);
      chk(got_commit == exp_commit, "R3", got_commit, exp_commit);
      if (m_pend) m_nv[m_pa] = m_pd;
      m_pend = 0;
      exp_commit = 0;
      bus_idle = 1;
   endtask

   task automatic write_txn(input logic [6:0] dev, input int mem, input bq_t d,
                            input bit do_stop, input string req);
      bit ack, match, burst, nvd, exp;
      int cnt, a;
      bus_idle = 0;
      match = (dev == DEV);
      i2c_start();
      wbyte({dev, 1'b0}, ack);
      chk(ack == match, match ? req : "R1", ack, match);
      wbyte(8'(mem), ack);
      chk(ack == match, match ? req : "R1", ack, match);
      if (match) m_nxt = mem % 16;
      burst = (mem == 8);
      cnt = 0;
      nvd = 0;
      foreach (d[i]) begin
         exp = match && !nvd && (cnt == 0 || burst);
         wbyte(d[i], ack);
         chk(ack == exp, match ? req : "R1", ack, exp);
         if (!exp) break;
         a = m_nxt;
         if (a == 8) m_ctrl = d[i];
         else if (m_ctrl[7]) begin
            m_pend = 1; m_pa = a; m_pd = d[i]; nvd = 1;
         end else m_vol[a] = d[i];
         m_nxt = (m_nxt + 1) % 16;
         cnt++;
      end
      if (do_stop) finish_stop();
   endtask

   task automatic read_txn(input bit rs, input int n, input string req);
      bit ack;
      logic [7:0] v, exp;
      bus_idle = 0;
      if (rs) begin
         i2c_rstart();
         m_pend = 0;
      end else i2c_start();
      wbyte({DEV, 1'b1}, ack);
      chk(ack == 1, req, ack, 1);
      for (int i = 0; i < n; i++) begin
         exp = m_read(m_nxt);
         m_nxt = (m_nxt + 1) % 16;
         rbyte(v, i < n - 1);
         chk(v == exp, req, v, exp);
      end
      finish_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bq_t q;
      for (int i = 0; i < 16; i++) begin
         m_vol[i] = 8'hA0 ^ 8'(i);
         m_nv[i]  = 8'hA0 ^ 8'(i);
      end
      m_ctrl = 8'h00;
      m_nxt  = 1;
      m_pend = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (5) @(negedge clk);
      // R9: reset state
      chk(sda_oe == 0, "R9", sda_oe, 0);
      chk(nv_commit == 0, "R9", nv_commit, 0);
      bus_idle = 1;

      // R8: current-address read after reset returns register 01h
      read_txn(0, 1, "R8");

      // R2: single working-copy write, read back through an address phase
      q = {8'h5A};
      write_txn(DEV, 0, q, 1, "R2");
      q = {};
      write_txn(DEV, 0, q, 0, "R2");
      read_txn(1, 1, "R2");

      // R3: select backing copy, read it, write it, commit at STOP
      q = {8'h80};
      write_txn(DEV, 8, q, 1, "R3");
      q = {};
      write_txn(DEV, 0, q, 0, "R3");
      read_txn(1, 1, "R3");
      q = {8'h3C};
      write_txn(DEV, 0, q, 1, "R3");
      q = {};
      write_txn(DEV, 0, q, 0, "R3");
      read_txn(1, 1, "R3");

      // R4: backing-copy write closed by a repeated START is dropped
      q = {8'h77};
      write_txn(DEV, 2, q, 0, "R4");
      read_txn(1, 1, "R4");

      // R5: burst from 08h into working copies
      q = {8'h00, 8'h11, 8'h22, 8'h33};
      write_txn(DEV, 8, q, 1, "R5");
      q = {};
      write_txn(DEV, 9, q, 0, "R5");
      read_txn(1, 3, "R5");
      // R5: burst ends at the first backing-copy byte
      q = {8'h80, 8'h44, 8'h55};
      write_txn(DEV, 8, q, 1, "R5");
      q = {};
      write_txn(DEV, 9, q, 0, "R5");
      read_txn(1, 2, "R5");

      // R6: burst from another address takes only one byte
      q = {8'h00};
      write_txn(DEV, 8, q, 1, "R6");
      q = {8'h66, 8'h99};
      write_txn(DEV, 3, q, 1, "R6");
      q = {};
      write_txn(DEV, 3, q, 0, "R6");
      read_txn(1, 2, "R6");

      // R1: foreign address is ignored
      q = {8'h12};
      write_txn(7'h2D, 3, q, 1, "R1");
      q = {};
      write_txn(DEV, 3, q, 0, "R1");
      read_txn(1, 1, "R1");

      // R8: current-address read continues after the last read
      read_txn(0, 1, "R8");

      // R7: multi-byte read across the top of the map, then continue
      q = {};
      write_txn(DEV, 15, q, 0, "R7");
      read_txn(1, 3, "R7");
      read_txn(0, 1, "R8");

      repeat (20) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule